// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the memory microsequence that takes a processor into an interrupt handler and back out again. A one-cycle service strobe with an 8-bit type number starts the entry path. The block saves the current flags, code segment and instruction pointer on the stack. It clears the interrupt-enable and trap flags once the flags word has been saved. It then fetches the handler's instruction pointer and code segment from a vector table that starts at physical address zero. Each table entry is four bytes, and the entry for a type lies at type×4.

A one-cycle return strobe starts the mirror path. It pops the instruction pointer, then the code segment, then the flags word, so the enable and trap bits come back exactly as they were saved. The surrounding core supplies the register values at the moment of the request. It takes the updated values from the result outputs when `done` pulses. Every access is one 16-bit word on a 20-bit physical address, and each access waits for `mem_rdy`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd`, `mem_wr` and all result outputs are 0, and while idle no memory strobe is raised.
- R2: In idle, a high `svc_req` is accepted at the clock edge and latches `svc_type` and the `cur_*` inputs. A high `ret_req` with `svc_req` low starts the return path. When both are high, the entry path wins. Requests that arrive while `busy` is high have no effect.
- R3: The entry path writes three words in this order: the unmodified flags at SS×16+(SP−2), then CS at SS×16+(SP−4), then IP at SS×16+(SP−6). Each push lowers SP by 2 before its write.
- R4: After the pushes, the entry path reads the new IP from physical address type×4 and then the new CS from type×4+2. Every vector address lies below 0x00400.
- R5: After an entry, `new_flags` equals the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits kept. `new_sp` is SP−6, and `new_ip`/`new_cs` hold the two vector words.
- R6: The return path reads IP at SS×16+SP, CS at SS×16+SP+2 and flags at SS×16+SP+4, in that order. `new_flags` is the popped word unaltered, including bits 9 and 8, and `new_sp` is SP+6.
- R7: At most one of `mem_rd` and `mem_wr` is high at a time. While `mem_rdy` is low, the address, the write data and the strobe stay unchanged. The sequence moves on only after an edge where the strobe and `mem_rdy` are both high.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse in which the result outputs already hold the new values, and `busy` is low in the following cycle.
- R9: SP arithmetic wraps modulo 2^16, and the stack physical address wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_req | input | 1 | Start entry sequence (sampled in idle) |
| svc_type | input | 8 | Interrupt type number for the entry |
| ret_req | input | 1 | Start return sequence (sampled in idle) |
| cur_flags | input | 16 | Flags value at the request |
| cur_cs | input | 16 | Code segment at the request |
| cur_ip | input | 16 | Instruction pointer at the request |
| cur_sp | input | 16 | Stack pointer at the request |
| cur_ss | input | 16 | Stack segment used for all stack accesses |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, taken on the ready edge |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdy | input | 1 | Access completes on an edge where this is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| new_flags | output | 16 | Resulting flags |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| new_sp | output | 16 | Resulting stack pointer |

## Verification
The bench stretches accesses with a pseudo-random ready pattern. A design that sampled read data or moved its address before the ready edge would pop or fetch the wrong word, and the per-cycle address comparison would show it. Flags of all ones and of only the two special bits expose a mask that clears the wrong bits, clears them before the flags push, or fails to restore them on return. A stack segment of 0xFFFF with SP 0x0004 forces wrap-around in both SP and the physical address, which catches a carry that leaks into bit 20 or a wrong pre-decrement order. Requests injected mid-sequence, and a service and return strobe raised together, catch a sequencer that restarts or takes the wrong path.

// File: rtl/irq_seq_pkg.sv
// Shared state encoding and state-class helpers for the interrupt
// entry/return sequencer. Assumes one memory access per access state.
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_PSH_FL = 4'd1,
        ST_PSH_CS = 4'd2,
        ST_PSH_IP = 4'd3,
        ST_VEC_IP = 4'd4,
        ST_VEC_CS = 4'd5,
        ST_POP_IP = 4'd6,
        ST_POP_CS = 4'd7,
        ST_POP_FL = 4'd8,
        ST_DONE   = 4'd9
    } seq_state_e;

    // True in the three stack-write states of the entry path.
    function automatic logic is_push(seq_state_e s);
        return (s == ST_PSH_FL) || (s == ST_PSH_CS) || (s == ST_PSH_IP);
    endfunction

    // True in the two vector-table read states.
    function automatic logic is_vec(seq_state_e s);
        return (s == ST_VEC_IP) || (s == ST_VEC_CS);
    endfunction

    // True in the three stack-read states of the return path.
    function automatic logic is_pop(seq_state_e s);
        return (s == ST_POP_IP) || (s == ST_POP_CS) || (s == ST_POP_FL);
    endfunction

endpackage

// File: rtl/irq_seq_fsm.sv
// Sequencer control. Walks the fixed entry order (three pushes, two vector
// reads) or the return order (three pops), one access per state, and moves
// on only when the access is acknowledged by mem_rdy.
// Assumes svc_req/ret_req are only meaningful while idle.
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_req,
    input  logic       ret_req,
    input  logic       mem_rdy,
    output seq_state_e state_q,
    output logic       step,
    output logic       load,
    output logic       busy,
    output logic       done,
    output logic       mem_rd,
    output logic       mem_wr
);

    seq_state_e state_d;

    // Strobe decode and handshake qualifiers from the current state.
    always_comb begin
        mem_wr = is_push(state_q);
        mem_rd = is_vec(state_q) || is_pop(state_q);
        step   = (mem_rd || mem_wr) && mem_rdy;
        load   = (state_q == ST_IDLE) && (svc_req || ret_req);
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
    end

    // Next-state selection; service requests outrank return requests.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (svc_req)      state_d = ST_PSH_FL;
                else if (ret_req) state_d = ST_POP_IP;
            end
            ST_PSH_FL: if (step) state_d = ST_PSH_CS;
            ST_PSH_CS: if (step) state_d = ST_PSH_IP;
            ST_PSH_IP: if (step) state_d = ST_VEC_IP;
            ST_VEC_IP: if (step) state_d = ST_VEC_CS;
            ST_VEC_CS: if (step) state_d = ST_DONE;
            ST_POP_IP: if (step) state_d = ST_POP_CS;
            ST_POP_CS: if (step) state_d = ST_POP_FL;
            ST_POP_FL: if (step) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R7: an unacknowledged access keeps the sequencer where it is.
    a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_rdy) |=> (state_q == $past(state_q)));

    // R2: a service request in idle always opens the entry path.
    a_r2_svc_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && svc_req) |=> (state_q == ST_PSH_FL));

    // R2: a lone return request opens the pop path.
    a_r2_ret_path: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !svc_req && ret_req) |=> (state_q == ST_POP_IP));

    // R8: the completion cycle is followed by idle.
    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/irq_seq_work.sv
// Working copy of the machine state for one sequence, plus the result
// registers handed to the core. Latches the request inputs on acceptance,
// applies the SP step, flag clear or loaded word on each acknowledged
// access, and publishes results on the final access.
// Assumes IE_POS and TR_POS are distinct bit positions below DATA_W.
module irq_seq_work
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8,
    parameter int IE_POS = 9,
    parameter int TR_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_q,
    input  logic              step,
    input  logic              load,
    input  logic [TYPE_W-1:0] svc_type,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [DATA_W-1:0] cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic [DATA_W-1:0] cur_sp,
    input  logic [DATA_W-1:0] cur_ss,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] w_flags,
    output logic [DATA_W-1:0] w_cs,
    output logic [DATA_W-1:0] w_ip,
    output logic [DATA_W-1:0] w_sp,
    output logic [DATA_W-1:0] w_ss,
    output logic [TYPE_W-1:0] w_type,
    output logic [DATA_W-1:0] res_flags,
    output logic [DATA_W-1:0] res_cs,
    output logic [DATA_W-1:0] res_ip,
    output logic [DATA_W-1:0] res_sp
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] SP_STEP  = DATA_W'(WORD_BYTES);
    localparam logic [DATA_W-1:0] CLR_BITS =
        (DATA_W'(1) << IE_POS) | (DATA_W'(1) << TR_POS);

    logic [DATA_W-1:0] flags_d, cs_d, ip_d, sp_d;
    logic              last_access;

    // Per-state update of the working values for an acknowledged access.
    always_comb begin
        flags_d = w_flags;
        cs_d    = w_cs;
        ip_d    = w_ip;
        sp_d    = w_sp;
        unique case (state_q)
            ST_PSH_FL: begin
                sp_d    = w_sp - SP_STEP;
                flags_d = w_flags & ~CLR_BITS;
            end
            ST_PSH_CS: sp_d = w_sp - SP_STEP;
            ST_PSH_IP: sp_d = w_sp - SP_STEP;
            ST_VEC_IP: ip_d = mem_rdata;
            ST_VEC_CS: cs_d = mem_rdata;
            ST_POP_IP: begin
                ip_d = mem_rdata;
                sp_d = w_sp + SP_STEP;
            end
            ST_POP_CS: begin
                cs_d = mem_rdata;
                sp_d = w_sp + SP_STEP;
            end
            ST_POP_FL: begin
                flags_d = mem_rdata;
                sp_d    = w_sp + SP_STEP;
            end
            default: ;
        endcase
        last_access = step && ((state_q == ST_VEC_CS) || (state_q == ST_POP_FL));
    end

    // Working registers: capture on acceptance, advance on each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_flags <= '0;
            w_cs    <= '0;
            w_ip    <= '0;
            w_sp    <= '0;
            w_ss    <= '0;
            w_type  <= '0;
        end else if (load) begin
            w_flags <= cur_flags;
            w_cs    <= cur_cs;
            w_ip    <= cur_ip;
            w_sp    <= cur_sp;
            w_ss    <= cur_ss;
            w_type  <= svc_type;
        end else if (step) begin
            w_flags <= flags_d;
            w_cs    <= cs_d;
            w_ip    <= ip_d;
            w_sp    <= sp_d;
        end
    end

    // Result registers: published together on the last access of a path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_flags <= '0;
            res_cs    <= '0;
            res_ip    <= '0;
            res_sp    <= '0;
        end else if (last_access) begin
            res_flags <= flags_d;
            res_cs    <= cs_d;
            res_ip    <= ip_d;
            res_sp    <= sp_d;
        end
    end

    // R5: once the flags word is pushed, both special bits read as zero.
    a_r5_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (state_q == ST_PSH_FL)) |=> (!w_flags[IE_POS] && !w_flags[TR_POS]));

    // R3: each acknowledged push leaves SP one word lower.
    a_r3_push_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_push(state_q)) |=> (w_sp == $past(w_sp) - SP_STEP));

    // R6: each acknowledged pop leaves SP one word higher.
    a_r6_pop_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_pop(state_q)) |=> (w_sp == $past(w_sp) + SP_STEP));

endmodule

// File: rtl/irq_seq_agen.sv
// Address and write-data generator. Forms stack addresses as segment
// shifted left plus offset (pre-decremented for pushes), and vector
// addresses as type scaled by the entry size from physical zero.
// Assumes the physical bus is ADDR_W bits and wraps on overflow.
module irq_seq_agen
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int TYPE_W    = 8,
    parameter int SEG_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_q,
    input  logic [DATA_W-1:0] w_flags,
    input  logic [DATA_W-1:0] w_cs,
    input  logic [DATA_W-1:0] w_ip,
    input  logic [DATA_W-1:0] w_sp,
    input  logic [DATA_W-1:0] w_ss,
    input  logic [TYPE_W-1:0] w_type,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int WORD_BYTES  = DATA_W / 8;
    localparam int VEC_BYTES   = 2 * WORD_BYTES;
    localparam int VEC_SHIFT   = $clog2(VEC_BYTES);
    localparam int TABLE_BYTES = (1 << TYPE_W) * VEC_BYTES;

    logic [DATA_W-1:0] stk_off;
    logic [ADDR_W-1:0] seg_base, stk_addr, vec_addr;

    // Stack offset: pushes address the word below the current SP.
    always_comb begin
        stk_off = w_sp;
        if (is_push(state_q)) stk_off = w_sp - DATA_W'(WORD_BYTES);
    end

    // Physical addresses for the stack and the vector table.
    always_comb begin
        seg_base = ADDR_W'(w_ss) << SEG_SHIFT;
        stk_addr = seg_base + ADDR_W'(stk_off);
        vec_addr = ADDR_W'(w_type) << VEC_SHIFT;
        if (state_q == ST_VEC_CS) vec_addr = vec_addr + ADDR_W'(WORD_BYTES);
    end

    // Bus address selection by state class.
    always_comb begin
        if (is_vec(state_q))                          mem_addr = vec_addr;
        else if (is_push(state_q) || is_pop(state_q)) mem_addr = stk_addr;
        else                                          mem_addr = '0;
    end

    // Write data follows the fixed push order.
    always_comb begin
        unique case (state_q)
            ST_PSH_FL: mem_wdata = w_flags;
            ST_PSH_CS: mem_wdata = w_cs;
            ST_PSH_IP: mem_wdata = w_ip;
            default:   mem_wdata = '0;
        endcase
    end

    // R4: vector fetches stay word aligned inside the table.
    a_r4_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        is_vec(state_q) |-> ((mem_addr < ADDR_W'(TABLE_BYTES)) && !mem_addr[0]));

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry/return sequencer top. Connects control, working state
// and address generation. The core supplies its registers at the request
// and takes new_* when done pulses. Assumes requests are single-cycle
// strobes and that memory completes an access on any edge with mem_rdy.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int TYPE_W    = 8,
    parameter int SEG_SHIFT = 4,
    parameter int IE_POS    = 9,
    parameter int TR_POS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_req,
    input  logic [TYPE_W-1:0] svc_type,
    input  logic              ret_req,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [DATA_W-1:0] cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic [DATA_W-1:0] cur_sp,
    input  logic [DATA_W-1:0] cur_ss,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] new_flags,
    output logic [DATA_W-1:0] new_cs,
    output logic [DATA_W-1:0] new_ip,
    output logic [DATA_W-1:0] new_sp
);

    seq_state_e        state_q;
    logic              step, load;
    logic [DATA_W-1:0] w_flags, w_cs, w_ip, w_sp, w_ss;
    logic [TYPE_W-1:0] w_type;

    irq_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_req (svc_req),
        .ret_req (ret_req),
        .mem_rdy (mem_rdy),
        .state_q (state_q),
        .step    (step),
        .load    (load),
        .busy    (busy),
        .done    (done),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr)
    );

    irq_seq_work #(
        .DATA_W (DATA_W),
        .TYPE_W (TYPE_W),
        .IE_POS (IE_POS),
        .TR_POS (TR_POS)
    ) u_work (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .step      (step),
        .load      (load),
        .svc_type  (svc_type),
        .cur_flags (cur_flags),
        .cur_cs    (cur_cs),
        .cur_ip    (cur_ip),
        .cur_sp    (cur_sp),
        .cur_ss    (cur_ss),
        .mem_rdata (mem_rdata),
        .w_flags   (w_flags),
        .w_cs      (w_cs),
        .w_ip      (w_ip),
        .w_sp      (w_sp),
        .w_ss      (w_ss),
        .w_type    (w_type),
        .res_flags (new_flags),
        .res_cs    (new_cs),
        .res_ip    (new_ip),
        .res_sp    (new_sp)
    );

    irq_seq_agen #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .TYPE_W    (TYPE_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .w_flags   (w_flags),
        .w_cs      (w_cs),
        .w_ip      (w_ip),
        .w_sp      (w_sp),
        .w_ss      (w_ss),
        .w_type    (w_type),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R1: no strobe while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr));

    // R7: never read and write together.
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: a waiting access keeps its address and data steady.
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_rdy) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R8: completion is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/irq_entry_seq_tb.sv
// Bench: behavioural memory with a vector table, an expected-access queue
// compared against the bus every clock, and per-sequence result checks.
module irq_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        svc_req = 1'b0, ret_req = 1'b0;
    logic [7:0]  svc_type = 8'h00;
    logic [15:0] cur_flags = '0, cur_cs = '0, cur_ip = '0, cur_sp = '0, cur_ss = '0;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rd, mem_wr, mem_rdy;
    logic        busy, done;
    logic [15:0] new_flags, new_cs, new_ip, new_sp;

    always #4 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .svc_type(svc_type),
        .ret_req(ret_req), .cur_flags(cur_flags), .cur_cs(cur_cs),
        .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_ss(cur_ss),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy),
        .busy(busy), .done(done), .new_flags(new_flags), .new_cs(new_cs),
        .new_ip(new_ip), .new_sp(new_sp)
    );

    // Expected bus accesses, appended by the stimulus, consumed by index.
    bit        exp_wr[$];
    bit [19:0] exp_addr[$];
    bit [15:0] exp_data[$];
    int        exp_req[$];

    logic [15:0] mem [bit [19:0]];
    bit          slow_mode = 1'b0;
    int          total = 0, bad = 0;
    int          mon_total = 0, mon_bad = 0;
    int          cyc = 0;

    function automatic logic [15:0] rd_mem(bit [19:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    function automatic bit [19:0] phys(bit [15:0] ss, bit [15:0] off);
        bit [19:0] b;
        b = {ss, 4'h0};
        return b + {4'h0, off};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic mchk(bit ok, int req, string what, logic [31:0] act, logic [31:0] expv);
        mon_total++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL R%0d %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    // Bus monitor and memory model: retire, compare, then drive ready/data.
    int        rd_idx = 0;
    bit        prev_xfer = 1'b0;
    bit [15:0] lfsr = 16'hACE1;
    bit        loaded = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rdy   = 1'b0;
            mem_rdata = 16'h0;
            prev_xfer = 1'b0;
            if (!loaded) begin
                for (int t = 0; t < 256; t++) begin
                    mem[20'(t * 4)]     = 16'(16'h1000 + t * 37);
                    mem[20'(t * 4 + 2)] = 16'(16'hA000 + t);
                end
                loaded = 1'b1;
            end
        end else begin
            if (prev_xfer && rd_idx < exp_wr.size()) begin
                if (exp_wr[rd_idx]) mem[exp_addr[rd_idx]] = exp_data[rd_idx];
                rd_idx++;
            end
            if (mem_rd || mem_wr) begin
                // R7: one strobe only
                mchk(!(mem_rd && mem_wr), 7, "both strobes", {mem_rd, mem_wr}, 2'b00);
                if (rd_idx >= exp_wr.size()) begin
                    mchk(1'b0, 2, "unexpected access addr", mem_addr, 0);
                end else begin
                    mchk(mem_wr == exp_wr[rd_idx], exp_req[rd_idx], "access kind",
                         mem_wr, exp_wr[rd_idx]);
                    mchk(mem_addr == exp_addr[rd_idx], exp_req[rd_idx], "address",
                         mem_addr, exp_addr[rd_idx]);
                    if (exp_wr[rd_idx])
                        mchk(mem_wdata == exp_data[rd_idx], exp_req[rd_idx], "write data",
                             mem_wdata, exp_data[rd_idx]);
                end
            end
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rdy = slow_mode ? lfsr[0] : 1'b1;
            mem_rdata = mem_rd ? rd_mem(mem_addr) : 16'h0;
            prev_xfer = (mem_rd || mem_wr) && mem_rdy;
        end
    end

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL R8 watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end

    function automatic void push_exp(bit wr, bit [19:0] a, bit [15:0] d, int req);
        exp_wr.push_back(wr);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_req.push_back(req);
    endfunction

    // Waits for done, with noise requests injected mid-sequence if asked.
    task automatic wait_done(bit noise, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (noise && i == 1) begin
                svc_req = 1'b1; ret_req = 1'b1; svc_type = 8'h55;
                cur_sp = 16'h0100; cur_flags = 16'h1111;
            end
            if (noise && i == 2) begin
                svc_req = 1'b0; ret_req = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic finish_seq(string req);
        @(negedge clk);
        chk(!busy && !done, "R8", "busy/done after pulse", {busy, done}, 2'b00);
        chk(rd_idx == exp_wr.size(), req, "accesses consumed", rd_idx, exp_wr.size());
    endtask

    task automatic run_entry(bit [7:0] t, bit [15:0] fl, bit [15:0] cs, bit [15:0] ip,
                             bit [15:0] sp, bit [15:0] ss, bit with_ret, bit noise);
        bit [15:0] vip, vcs;
        bit seen;
        vip = rd_mem({10'h0, t, 2'b00});
        vcs = rd_mem({10'h0, t, 2'b10});
        push_exp(1'b1, phys(ss, sp - 16'd2), fl, 3);   // R3 flags first
        push_exp(1'b1, phys(ss, sp - 16'd4), cs, 3);   // R3 then CS
        push_exp(1'b1, phys(ss, sp - 16'd6), ip, 3);   // R3 then IP
        push_exp(1'b0, {10'h0, t, 2'b00}, 16'h0, 4);   // R4 IP vector
        push_exp(1'b0, {10'h0, t, 2'b10}, 16'h0, 4);   // R4 CS vector
        @(negedge clk);
        svc_type = t; cur_flags = fl; cur_cs = cs; cur_ip = ip; cur_sp = sp; cur_ss = ss;
        svc_req = 1'b1; ret_req = with_ret;
        @(negedge clk);
        svc_req = 1'b0; ret_req = 1'b0;
        cur_flags = 16'h0; cur_cs = 16'h0; cur_ip = 16'h0; cur_sp = 16'h0; cur_ss = 16'h0;
        chk(busy, "R8", "busy after accept", busy, 1);
        wait_done(noise, seen);
        chk(seen, "R8", "done seen", seen, 1);
        chk(new_flags == (fl & 16'hFCFF), "R5", "entry flags", new_flags, fl & 16'hFCFF);
        chk(new_ip == vip, "R5", "entry ip", new_ip, vip);
        chk(new_cs == vcs, "R5", "entry cs", new_cs, vcs);
        chk(new_sp == 16'(sp - 16'd6), "R5", "entry sp", new_sp, sp - 16'd6);
        finish_seq("R3");
    endtask

    task automatic run_return(bit [15:0] sp, bit [15:0] ss, bit [15:0] efl,
                              bit [15:0] ecs, bit [15:0] eip);
        bit seen;
        push_exp(1'b0, phys(ss, sp), 16'h0, 6);           // R6 IP first
        push_exp(1'b0, phys(ss, sp + 16'd2), 16'h0, 6);   // R6 then CS
        push_exp(1'b0, phys(ss, sp + 16'd4), 16'h0, 6);   // R6 then flags
        @(negedge clk);
        cur_sp = sp; cur_ss = ss; cur_flags = 16'h0; cur_cs = 16'h7777; cur_ip = 16'h8888;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk(busy, "R8", "busy after return accept", busy, 1);
        wait_done(1'b0, seen);
        chk(seen, "R8", "return done seen", seen, 1);
        chk(new_ip == eip, "R6", "return ip", new_ip, eip);
        chk(new_cs == ecs, "R6", "return cs", new_cs, ecs);
        chk(new_flags == efl, "R6", "return flags incl bits 9/8", new_flags, efl);
        chk(new_sp == 16'(sp + 16'd6), "R6", "return sp", new_sp, sp + 16'd6);
        finish_seq("R6");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        chk(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        chk(new_flags == 0 && new_sp == 0 && new_cs == 0 && new_ip == 0, "R1",
            "results in reset", new_flags, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_rd && !mem_wr && !busy, "R1", "idle quiet", {mem_rd, mem_wr, busy}, 0);

        // Entry with all flags set, then return restores them (R5, R6).
        run_entry(8'h02, 16'hFFFF, 16'h1234, 16'h5678, 16'h2000, 16'h3000, 1'b0, 1'b0);
        run_return(16'h1FFA, 16'h3000, 16'hFFFF, 16'h1234, 16'h5678);

        // Slow memory with mid-sequence requests that must be ignored (R2, R7).
        slow_mode = 1'b1;
        run_entry(8'hFF, 16'h0300, 16'hBEEF, 16'hCAFE, 16'h0800, 16'h4000, 1'b0, 1'b1);
        run_return(16'h07FA, 16'h4000, 16'h0300, 16'hBEEF, 16'hCAFE);

        // Both requests together: entry wins (R2); zero flags stay zero.
        slow_mode = 1'b0;
        run_entry(8'h00, 16'h0000, 16'h0F0F, 16'hF0F0, 16'h0010, 16'h0000, 1'b1, 1'b0);
        run_return(16'h000A, 16'h0000, 16'h0000, 16'h0F0F, 16'hF0F0);

        // R9: SP and physical address wrap in both directions.
        slow_mode = 1'b1;
        run_entry(8'h21, 16'h0A55, 16'h1357, 16'h2468, 16'h0004, 16'hFFFF, 1'b0, 1'b0);
        run_return(16'hFFFE, 16'hFFFF, 16'h0A55, 16'h1357, 16'h2468);
        chk(new_sp == 16'h0004, "R9", "sp wrapped back", new_sp, 16'h0004);

        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

endmodule